// File: doc/BRIEF.md
# Serial Flash Status Write Guard

This block holds the status register of a serial NOR flash and the logic that decides whether software may rewrite it. A host talks to the block over a mode-0 SPI slave port. Two commands are decoded. The enable command arms a write-enable latch. The status-write command carries one data byte that replaces the writable status fields. All SPI pins and the active-low write-protect pin are brought into a single system clock domain. Every decision is made in that domain.

A status write goes through only when two conditions hold. The write-enable latch must be armed, and the device must not be in hardware-protected mode. Hardware-protected mode is the combination of a sticky write-disable bit in the status register and a low level on the write-protect pin. It can be entered in either order, and it is left only by raising the pin. The three zone-select bits name the software-protected region. They are exported, together with the hardware-protected flag, for the erase and program logic that sits downstream.

Top module: `flash_sr_guard`

## Requirements
- R1: A frame of exactly 8 SCK rising edges whose byte is 0x06 sets the write-enable latch, which is bit 1 of `status_byte`.
- R2: A frame of exactly 16 edges whose first byte is 0x01, received while the latch is clear, leaves `status_byte` unchanged.
- R3: While bit 7 (write-disable) is 0, an enabled status write is accepted whatever the level of `wp_n`.
- R4: While bit 7 is 1 and `wp_n` is high, an enabled status write is accepted.
- R5: While bit 7 is 1 and `wp_n` is low, a status write is rejected. The status bits and the latch keep their values.
- R6: `hw_protected` is 1 exactly when bit 7 is 1 and `wp_n` is low. It is reached by setting the bit while the pin is low, or by lowering the pin after the bit is set. It clears only when the pin goes high.
- R7: An accepted write loads data bit 7 into bit 7 and data bits 4:2 into bits 4:2, then clears the latch. Data bits 6:5 and 1:0 have no effect, and bits 6:5 and 0 read as 0.
- R8: A frame with any other edge count, or with an unknown opcode, changes nothing.
- R9: `spi_so_en` stays 0 at all times, so the serial output is never driven.
- R10: After reset, `status_byte` is 0x00 and `hw_protected` is 0.
- R11: `prot_zone` always equals status bits 4:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI clock, mode 0 |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in, MSB first |
| wp_n | input | 1 | Write-protect pin, active low |
| spi_so | output | 1 | Serial data out (undriven) |
| spi_so_en | output | 1 | Output enable for spi_so, always 0 |
| status_byte | output | 8 | Status register: bit7 write-disable, bits4:2 zone, bit1 latch |
| hw_protected | output | 1 | Hardware-protected mode flag |
| prot_zone | output | 3 | Software-protected region code |

## Verification
The status write is exercised with the write-disable bit at 0 and at 1, each against both pin levels, with the latch both armed and clear. These combinations separate a gate that ignores the pin from one that ignores the latch or the sticky bit. Protected mode is entered once in each order and left by raising the pin. This shows that the flag follows the pin as well as the bit. Frames of 7, 9, 15 and 17 edges, and a near-miss opcode, show that the decoder counts edges exactly rather than just watching for a byte.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int OP_W    = 8;
  localparam int DATA_W  = 8;
  localparam int ZONE_W  = 3;
  localparam logic [OP_W-1:0] OP_ARM    = 8'h06;
  localparam logic [OP_W-1:0] OP_SRLOAD = 8'h01;
  localparam int LOCK_BIT  = 7;
  localparam int ZONE_LSB  = 2;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_ARM  = 2'd1,
    EV_LOAD = 2'd2
  } frame_ev_e;
endpackage

// File: rtl/fsr_sync.sv
module fsr_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fsr_frame_rx.sv
module fsr_frame_rx
  import fsr_pkg::*;
#(
  parameter int CMD_W = OP_W,
  parameter int ARG_W = DATA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             si,
  output frame_ev_e        ev,
  output logic [ARG_W-1:0] ev_arg
);
  localparam int FRAME_W = CMD_W + ARG_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W + 1);

  logic               sck_d, cs_d;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] shreg;
  logic               sck_rise, cs_rise;

  assign sck_rise = sck & ~sck_d;
  assign cs_rise  = cs_n & ~cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
      cnt    <= '0;
      shreg  <= '0;
      ev     <= EV_NONE;
      ev_arg <= '0;
    end else begin
      sck_d <= sck;
      cs_d  <= cs_n;
      ev    <= EV_NONE;
      if (cs_n) begin
        cnt <= '0;
        if (cs_rise) begin
          if (cnt == CNT_W'(CMD_W) && shreg[CMD_W-1:0] == OP_ARM) begin
            ev <= EV_ARM;
          end else if (cnt == CNT_W'(FRAME_W) &&
                       shreg[FRAME_W-1 -: CMD_W] == OP_SRLOAD) begin
            ev     <= EV_LOAD;
            ev_arg <= shreg[ARG_W-1:0];
          end
        end
      end else if (sck_rise) begin
        shreg <= {shreg[FRAME_W-2:0], si};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsr_status_core.sv
module fsr_status_core
  import fsr_pkg::*;
#(
  parameter int ARG_W = DATA_W,
  parameter int ZW    = ZONE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  frame_ev_e        ev,
  input  logic [ARG_W-1:0] ev_arg,
  input  logic             wp_n,
  output logic             lock_q,
  output logic [ZW-1:0]    zone_q,
  output logic             arm_q,
  output logic             hwp_q
);
  logic gate_open;
  logic unused_arg;

  assign gate_open  = arm_q & ~(lock_q & ~wp_n);
  assign unused_arg = ^{ev_arg[ARG_W-1:LOCK_BIT+1], ev_arg[LOCK_BIT-1:ZONE_LSB+ZW],
                        ev_arg[ZONE_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      zone_q <= '0;
      arm_q  <= 1'b0;
      hwp_q  <= 1'b0;
    end else begin
      hwp_q <= lock_q & ~wp_n;
      case (ev)
        EV_ARM: arm_q <= 1'b1;
        EV_LOAD: begin
          if (gate_open) begin
            lock_q <= ev_arg[LOCK_BIT];
            zone_q <= ev_arg[ZONE_LSB +: ZW];
            arm_q  <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
  import fsr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  input  logic              wp_n,
  output logic              spi_so,
  output logic              spi_so_en,
  output logic [DATA_W-1:0] status_byte,
  output logic              hw_protected,
  output logic [ZONE_W-1:0] prot_zone
);
  logic [3:0]        pins_s;
  logic              sck_s, cs_s, si_s, wp_s;
  frame_ev_e         ev;
  logic [DATA_W-1:0] ev_arg;
  logic              lock_q, arm_q;
  logic [ZONE_W-1:0] zone_q;

  fsr_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) sync_i (
    .clk(clk), .rst(rst),
    .d({spi_cs_n, wp_n, spi_sck, spi_si}),
    .q(pins_s)
  );
  assign {cs_s, wp_s, sck_s, si_s} = pins_s;

  fsr_frame_rx #(.CMD_W(OP_W), .ARG_W(DATA_W)) rx_i (
    .clk(clk), .rst(rst), .sck(sck_s), .cs_n(cs_s), .si(si_s),
    .ev(ev), .ev_arg(ev_arg)
  );

  fsr_status_core #(.ARG_W(DATA_W), .ZW(ZONE_W)) core_i (
    .clk(clk), .rst(rst), .ev(ev), .ev_arg(ev_arg), .wp_n(wp_s),
    .lock_q(lock_q), .zone_q(zone_q), .arm_q(arm_q), .hwp_q(hw_protected)
  );

  always_comb begin
    status_byte = '0;
    status_byte[LOCK_BIT] = lock_q;
    status_byte[ZONE_LSB +: ZONE_W] = zone_q;
    status_byte[1] = arm_q;
  end

  assign prot_zone = zone_q;
  assign spi_so    = 1'b0;
  assign spi_so_en = 1'b0;
endmodule

// File: rtl/fsr_guard_chk.sv
module fsr_guard_chk
  import fsr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wp_s,
  input logic              lock_q,
  input logic [ZONE_W-1:0] zone_q,
  input logic              arm_q,
  input logic              hwp,
  input frame_ev_e         ev
);
  a_r2_write_needs_arm: assert property (@(posedge clk) disable iff (rst)
    (lock_q != $past(lock_q) || zone_q != $past(zone_q)) |-> $past(arm_q));

  a_r7_arm_clears: assert property (@(posedge clk) disable iff (rst)
    (lock_q != $past(lock_q) || zone_q != $past(zone_q)) |-> !arm_q);

  a_r5_hpm_freezes: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !wp_s) |=> (lock_q && $stable(zone_q)));

  a_r5_reject_keeps_arm: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_LOAD && arm_q && lock_q && !wp_s) |=> arm_q);

  a_r6_hpm_flag: assert property (@(posedge clk) disable iff (rst)
    hwp == $past(lock_q && !wp_s));

  a_r1_arm_sets: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_ARM) |=> arm_q);
endmodule

bind flash_sr_guard fsr_guard_chk chk_i (
  .clk(clk), .rst(rst), .wp_s(wp_s), .lock_q(lock_q), .zone_q(zone_q),
  .arm_q(arm_q), .hwp(hw_protected), .ev(ev)
);

// File: tb/flash_sr_guard_tb_top.sv
`timescale 1ns/1ps
module flash_sr_guard_tb_top;
  localparam int HALF   = 8;
  localparam int SETTLE = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1;
  logic so, so_en, hwp;
  logic [7:0] status;
  logic [2:0] zone;

  int checks = 0, errors = 0, settle = SETTLE;
  bit done = 0;
  int m_lock = 0, m_zone = 0, m_arm = 0;

  always #2.5 clk = ~clk;

  flash_sr_guard dut_i (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .wp_n(wp_n), .spi_so(so), .spi_so_en(so_en), .status_byte(status),
    .hw_protected(hwp), .prot_zone(zone)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_status();
    return (m_lock << 7) | (m_zone << 2) | (m_arm << 1);
  endfunction

  // per-cycle comparison against the behavioural model, off the clock edges
  always begin
    @(posedge clk); #1;
    if (!rst && !done) begin
      chk("R9 so_en", int'(so_en), 0);
      if (settle > 0) settle--;
      else begin
        chk("R7 status vs model", int'(status), model_status());
        chk("R6 hwp vs model", int'(hwp), int'(m_lock == 1 && wp_n == 1'b0));
        chk("R11 zone vs model", int'(zone), m_zone);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [31:0] val, input int nbits);
    cs_n = 1'b0; settle = SETTLE;
    cyc(HALF);
    for (int i = nbits - 1; i >= 0; i--) begin
      si = val[i]; cyc(HALF);
      sck = 1'b1; cyc(HALF);
      sck = 1'b0;
    end
    cyc(HALF);
    cs_n = 1'b1; settle = SETTLE;
    if (nbits == 8 && val[7:0] == 8'h06) m_arm = 1;
    else if (nbits == 16 && val[15:8] == 8'h01 && m_arm == 1 &&
             !(m_lock == 1 && wp_n == 1'b0)) begin
      m_lock = int'(val[7]); m_zone = int'(val[4:2]); m_arm = 0;
    end
    cyc(SETTLE + 4);
  endtask

  task automatic set_wp(input logic v);
    wp_n = v; settle = SETTLE; cyc(SETTLE + 4);
  endtask

  initial begin
    cyc(5);
    rst = 1'b0;
    cyc(SETTLE + 2);
    chk("R10 reset status", int'(status), 0);
    chk("R10 reset hwp", int'(hwp), 0);

    frame(32'h011C, 16);
    chk("R2 write without latch", int'(status), 8'h00);
    frame(32'h06, 8);
    chk("R1 latch set", int'(status), 8'h02);
    frame(32'h01FF, 16);
    chk("R3 R7 accepted, reserved ignored", int'(status), 8'h9C);
    chk("R11 zone", int'(zone), 3'b111);
    chk("R6 bit set, pin high", int'(hwp), 0);

    frame(32'h06, 8);
    frame(32'h0188, 16);
    chk("R4 accepted with pin high", int'(status), 8'h88);

    set_wp(1'b0);
    chk("R6 entered pin after bit", int'(hwp), 1);
    frame(32'h06, 8);
    frame(32'h0100, 16);
    chk("R5 rejected under protection", int'(status), 8'h8A);
    chk("R11 zone frozen", int'(zone), 3'b010);

    set_wp(1'b1);
    chk("R6 exit by pin high", int'(hwp), 0);
    frame(32'h0104, 16);
    chk("R4 accepted after exit", int'(status), 8'h04);

    set_wp(1'b0);
    frame(32'h06, 8);
    frame(32'h0194, 16);
    chk("R3 pin ignored while bit clear", int'(status), 8'h94);
    chk("R6 entered bit after pin", int'(hwp), 1);

    set_wp(1'b1);
    frame(32'h06, 8);
    frame(32'h0100, 16);
    chk("R7 cleared all", int'(status), 8'h00);

    frame(32'h06 >> 1, 7);
    chk("R8 seven-edge arm", int'(status), 8'h00);
    frame(32'h006, 9);
    chk("R8 nine-edge arm", int'(status), 8'h00);
    frame(32'h07, 8);
    chk("R8 unknown opcode", int'(status), 8'h00);
    frame(32'h06, 8);
    frame(32'h01FC >> 1, 15);
    chk("R8 fifteen-edge write", int'(status), 8'h02);
    frame(32'h1FC << 0 | 32'h00800, 17);
    chk("R8 seventeen-edge write", int'(status), 8'h02);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule